// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides, every cycle, whether a hart should take an interrupt now and which cause number to report. It forms candidates from the pending and enable vectors. It splits them by the delegation mask into machine-handled and supervisor-handled groups, and gates each group by whether that level currently accepts interrupts. The gate depends on the current privilege level and on the matching global enable bit.

Among the surviving bits the lowest index wins. The cause word carries that index in its low bits, and its most significant bit is set to mark the event as an interrupt rather than an exception. The trap-entry logic of the core uses the result. A parameter adds an optional register stage on the outputs for timing closure.

Top module: `irq_pick`

## Requirements
- R1: A bit is a candidate only when it is set in both `pend_i` and `enab_i`; a pending bit whose enable is 0 is never taken.
- R2: A candidate whose `deleg_i` bit is 0 is eligible when `priv_i` is 0, 1 or 2, or when `priv_i` is 3 and `mie_i` is 1.
- R3: A candidate whose `deleg_i` bit is 1 is eligible when `priv_i` is 0, or when `priv_i` is 1 and `sie_i` is 1; at `priv_i` 2 or 3 it is never eligible.
- R4: `take_o` is 1 exactly when at least one bit is eligible.
- R5: When several bits are eligible, the lowest-numbered one is reported.
- R6: When `take_o` is 1, `cause_o` has bit XLEN-1 set, the winning index in bits $clog2(XLEN)-1:0, and all other bits 0.
- R7: When no bit is eligible, `take_o` is 0 and `cause_o` is all zeros.
- R8: With REGISTERED=1, `take_o` and `cause_o` show the result for the inputs present at the previous rising clock edge, and a high `rst` at a rising edge clears both to 0.
- R9: With REGISTERED=0, `take_o` and `cause_o` follow the inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | XLEN | Pending interrupt bits |
| enab_i | input | XLEN | Per-interrupt enable bits |
| deleg_i | input | XLEN | Delegation mask: 1 sends the bit to supervisor handling |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | XLEN | Interrupt flag in the top bit, winning index in the low bits |

## Verification
The main function is tried at every privilege level, with and without each global enable, and with delegated and non-delegated bits mixed in one vector. This separates the machine gate from the supervisor gate, and it shows that the hypervisor level blocks delegated bits. Vectors with pending bits that are masked by the enables separate the candidate step from the gating step. Vectors with several eligible bits, including ones where the lower bit is gated off, show that priority is applied after qualification. The top bit index 63 checks the cause packing, and a second, registered instance checks the one-cycle latency and the reset clear.

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int XLEN       = 64,
  parameter bit REGISTERED = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] enab_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int IW = $clog2(XLEN);

  logic            m_on, s_on, take_c;
  logic [XLEN-1:0] cand, elig, cause_c;
  logic [IW-1:0]   idx;

  assign m_on = (priv_i != 2'd3) || mie_i;
  assign s_on = (priv_i == 2'd0) || ((priv_i == 2'd1) && sie_i);
  assign cand = pend_i & enab_i;
  assign elig = (cand & ~deleg_i & {XLEN{m_on}}) | (cand & deleg_i & {XLEN{s_on}});

  always_comb begin
    idx = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (elig[i]) idx = IW'(i);
  end

  assign take_c  = |elig;
  assign cause_c = take_c ? {1'b1, {(XLEN-1-IW){1'b0}}, idx} : '0;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          take_o  <= 1'b0;
          cause_o <= '0;
        end else begin
          take_o  <= take_c;
          cause_o <= cause_c;
        end
      end

      p_reg_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (take_o == $past(take_c)) && (cause_o == $past(cause_c)));
    end else begin : g_comb
      assign take_o  = take_c;
      assign cause_o = cause_c;
    end
  endgenerate

  p_cand_needed_r1: assert property (@(posedge clk) disable iff (rst)
    take_c |-> (pend_i & enab_i) != '0);

  p_winner_eligible_r4: assert property (@(posedge clk) disable iff (rst)
    take_c |-> elig[idx]);

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (rst)
    take_c |-> (elig & ((XLEN'(1) << idx) - XLEN'(1))) == '0);

  p_cause_flag_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> cause_o[XLEN-1]);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> cause_o == '0);

  p_deleg_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (priv_i[1] && (cand & ~deleg_i) == '0) |-> !take_c);
endmodule

// File: tb/test_irq_pick.sv
module test_irq_pick;
  localparam int NV = 14;

  localparam logic [15:0] T_PEND [NV] = '{16'h0080,16'h0080,16'h0080,16'h0080,16'h0022,16'h0022,16'h0002,
                                          16'h0002,16'h0002,16'h8001,16'h8000,16'h0000,16'hF0F0,16'h0A00};
  localparam logic [15:0] T_ENAB [NV] = '{16'hFFFF,16'hFFFF,16'hFFFF,16'h0000,16'h00FF,16'h00FF,16'hFFFF,
                                          16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'h0F00,16'hFFFF};
  localparam logic [15:0] T_DELG [NV] = '{16'h0000,16'h0000,16'h0000,16'h0000,16'h0002,16'h0002,16'h0002,
                                          16'h0002,16'h0002,16'h0000,16'h0000,16'h0000,16'h0000,16'h0200};
  localparam logic [1:0]  T_PRIV [NV] = '{2'd3,2'd3,2'd1,2'd0,2'd1,2'd1,2'd2,2'd3,2'd0,2'd0,2'd2,2'd0,2'd0,2'd1};
  localparam logic        T_MIE  [NV] = '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1};
  localparam logic        T_SIE  [NV] = '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0};
  localparam logic        T_TAKE [NV] = '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1};
  localparam logic [5:0]  T_IDX  [NV] = '{6'd7,6'd0,6'd7,6'd0,6'd1,6'd5,6'd0,6'd0,6'd1,6'd0,6'd15,6'd0,6'd0,6'd11};
  localparam string       T_REQ  [NV] = '{"R2","R2","R2","R1","R5","R3","R3","R3","R3","R5","R2","R7","R1","R3"};

  logic clk = 1'b0, rst = 1'b1;
  logic [63:0] pend = '0, enab = '0, deleg = '0;
  logic [1:0]  priv = '0;
  logic        mie = 1'b0, sie = 1'b0;
  logic        take;
  logic [63:0] cause;
  logic [31:0] p32 = '0;
  logic        take32;
  logic [31:0] cause32;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_pick #(.XLEN(64), .REGISTERED(1'b0)) i_irq_pick (
    .clk(clk), .rst(rst), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
    .priv_i(priv), .mie_i(mie), .sie_i(sie), .take_o(take), .cause_o(cause));

  irq_pick #(.XLEN(32), .REGISTERED(1'b1)) i_irq_pick_reg (
    .clk(clk), .rst(rst), .pend_i(p32), .enab_i(32'hFFFF_FFFF), .deleg_i(32'h0),
    .priv_i(2'd3), .mie_i(1'b1), .sie_i(1'b0), .take_o(take32), .cause_o(cause32));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ecause(input logic t, input logic [5:0] i);
    return t ? ({1'b1, 63'b0} | 64'(i)) : 64'h0;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset take", 64'(take32), 64'h0);
    check("R8 reset cause", 64'(cause32), 64'h0);
    @(negedge clk) rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      pend = 64'(T_PEND[v]); enab = 64'(T_ENAB[v]); deleg = 64'(T_DELG[v]);
      priv = T_PRIV[v]; mie = T_MIE[v]; sie = T_SIE[v];
      #1;
      check({T_REQ[v], " R4 take"}, 64'(take), 64'(T_TAKE[v]));
      check({T_REQ[v], " R6 cause"}, cause, ecause(T_TAKE[v], T_IDX[v]));
    end

    pend = 64'h8000_0000_0000_0000; enab = '1; deleg = '0; priv = 2'd0;
    #1;
    check("R6 top index", cause, 64'h8000_0000_0000_003F);
    pend = 64'h8000_0000_0000_0400;
    #1;
    check("R5 lowest of two", cause, 64'h8000_0000_0000_000A);
    pend = '0;
    #1;
    check("R7 idle take", 64'(take), 64'h0);
    check("R7 idle cause", cause, 64'h0);
    check("R9 same-cycle", 64'(take), 64'h0);

    @(negedge clk) p32 = 32'h0000_0030;
    #1;
    check("R8 before edge", 64'(take32), 64'h0);
    @(posedge clk); #1;
    check("R8 after edge take", 64'(take32), 64'h1);
    check("R8 after edge cause", 64'(cause32), 64'h8000_0004);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R8 reset clears", 64'(cause32), 64'h0);
    @(negedge clk) begin rst = 1'b0; p32 = 32'h0; end
    @(posedge clk); #1;
    check("R8 idle after", 64'(take32), 64'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule